// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs trap entry for a core with user, supervisor and machine privilege levels. When the pipeline raises a trap request with an exception code, an interrupt flag and the address of the trapping instruction, the block uses the current privilege and two delegation masks to pick the handler level. In one clock edge it then records the cause and return address in that level's own registers, pushes that level's interrupt-enable bit onto its previous-enable slot, records the previous privilege where that level keeps it, and switches to the handler privilege. In the same cycle as the request it pulses `trap_taken` and presents the handler base on the fetch redirect port, so the pipeline can flush.

The trap-vector bases come in from the CSR file. The return logic restores the privilege and enable bits after a handler through a small mode-load port. Reset clears every register the block holds and places the core in machine mode. In the first cycle after reset the block redirects fetch to a fixed reset vector.

The controller is a two-state machine. `ST_BOOT` is entered on reset and lasts one cycle; it drives the reset vector and ignores trap requests. It moves unconditionally to `ST_RUN` (transition *boot_done*). `ST_RUN` accepts traps (self-transition *trap_commit* when a request is present, *idle* otherwise). Reset returns it to `ST_BOOT` from either state.

Top module: `trap_entry_ctl`

## Requirements
- R1: While reset is low, and after it is released, the block holds privilege M (11), clears all cause and EPC registers and all enable, previous-enable, SPP and MPP bits, and keeps `trap_taken` low. In the first cycle after release it drives `redirect_valid`=1 with `redirect_pc`=RESET_VEC and ignores `trap_req`.
- R2: The handler level defaults to M (privilege encoding 00=U, 01=S, 11=M). When the current level is not M and bit `trap_code` of `medeleg_mask` is set, the handler level is S instead.
- R3: When the current level is U and bit `trap_code` of `sedeleg_mask` is set, the handler level is U, whatever the machine mask holds.
- R4: Only the handler level's cause register is written. It receives `trap_code` in its low CODE_W bits and `trap_is_irq` in its most significant bit, and all other bits are zero.
- R5: Only the handler level's EPC register is written, and it receives `trap_pc`. The other levels' cause and EPC registers keep their values.
- R6: For a U handler, the U previous-enable bit takes the old U enable and the U enable clears. Enable bits are indexed [0]=U, [1]=S, [2]=M.
- R7: For an S handler, SPP takes 0 if the trap came from U and 1 if it came from S, the S previous-enable bit takes the old S enable, and the S enable clears.
- R8: For an M handler, MPP takes the prior privilege in two-bit form, the M previous-enable bit takes the old M enable, and the M enable clears.
- R9: In `ST_RUN`, a `trap_req` cycle raises `trap_taken` and `redirect_valid` and drives `redirect_pc` to the handler level's vector input with bits [1:0] cleared. The register updates commit at the next edge, and privilege then equals the handler level.
- R10: `mode_ld_en` loads `mode_ld_ie` into the enable bits and `mode_ld_priv` into the privilege, except that the reserved code 10 leaves the privilege unchanged. When a trap commits in the same cycle, the load is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request from the pipeline |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_is_irq | input | 1 | Request is an interrupt |
| trap_pc | input | XLEN | Address of the trapping instruction |
| medeleg_mask | input | 2**CODE_W | Machine-to-supervisor delegation mask |
| sedeleg_mask | input | 2**CODE_W | Supervisor-to-user delegation mask |
| utvec | input | XLEN | U handler base |
| stvec | input | XLEN | S handler base |
| mtvec | input | XLEN | M handler base |
| mode_ld_en | input | 1 | Restore privilege and enables |
| mode_ld_priv | input | 2 | Privilege to restore |
| mode_ld_ie | input | 3 | Enables to restore |
| priv_mode | output | 2 | Current privilege |
| trap_taken | output | 1 | Trap commit pulse |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | XLEN | Fetch redirect target |
| ucause | output | XLEN | U cause register |
| scause | output | XLEN | S cause register |
| mcause | output | XLEN | M cause register |
| uepc | output | XLEN | U return address |
| sepc | output | XLEN | S return address |
| mepc | output | XLEN | M return address |
| status_ie | output | 3 | Enable bits {M,S,U} |
| status_pie | output | 3 | Previous-enable bits {M,S,U} |
| status_spp | output | 1 | S previous privilege |
| status_mpp | output | 2 | M previous privilege |

## Verification
The bench builds the block with XLEN=16 and CODE_W=4, so the delegation masks are 16 bits wide. At that size every trap code, both values of the interrupt flag, all three originating privileges and all four combinations of the two delegation bits can be swept: 384 traps in total, with the enable bits cycled through all eight patterns. The masks set every bit except the selected one, or the reverse, so a wrong mask index changes the handler level. Directed cases cover the boot cycle, the reserved privilege load, a load that collides with a trap, and a reset in mid-run.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    localparam int NUM_LEVELS = 3;

    // Row index of a privilege level in the per-level register banks.
    function automatic logic [1:0] level_row(priv_e p);
        unique case (p)
            PRIV_U:  level_row = 2'd0;
            PRIV_S:  level_row = 2'd1;
            default: level_row = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/trap_deleg.sv
module trap_deleg
    import trap_entry_pkg::*;
#(
    parameter int CODE_W = 5,
    localparam int NCODE = 1 << CODE_W
) (
    input  priv_e              cur_priv,
    input  logic [CODE_W-1:0]  code,
    input  logic [NCODE-1:0]   medeleg,
    input  logic [NCODE-1:0]   sedeleg,
    output priv_e              tgt_priv
);

    always_comb begin
        tgt_priv = PRIV_M;
        if (cur_priv != PRIV_M && medeleg[code]) begin
            tgt_priv = PRIV_S;
        end
        if (cur_priv == PRIV_U && sedeleg[code]) begin
            tgt_priv = PRIV_U;
        end
    end

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
    import trap_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [1:0]                       wr_row,
    input  logic [CODE_W-1:0]                code,
    input  logic                             is_irq,
    input  logic [XLEN-1:0]                  pc,
    output logic [NUM_LEVELS-1:0][XLEN-1:0]  cause_q,
    output logic [NUM_LEVELS-1:0][XLEN-1:0]  epc_q
);

    logic [XLEN-1:0] cause_val;

    always_comb begin
        cause_val               = '0;
        cause_val[CODE_W-1:0]   = code;
        cause_val[XLEN-1]       = is_irq;
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cause_q[g] <= '0;
                epc_q[g]   <= '0;
            end else if (wr_en && wr_row == 2'(g)) begin
                cause_q[g] <= cause_val;
                epc_q[g]   <= pc;
            end
        end
    end

    a_r5_sepc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_row == 2'd1) |=> (epc_q[1] == $past(pc)));

    a_r4_mcause_irq_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_row == 2'd2) |=> (cause_q[2][XLEN-1] == $past(is_irq)));

endmodule

// File: rtl/trap_status.sv
module trap_status
    import trap_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trap_fire,
    input  priv_e      tgt_priv,
    input  priv_e      cur_priv,
    input  logic       ld_en,
    input  logic [2:0] ld_ie,
    output logic [2:0] ie_q,
    output logic [2:0] pie_q,
    output logic       spp_q,
    output logic [1:0] mpp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= '0;
            pie_q <= '0;
            spp_q <= 1'b0;
            mpp_q <= 2'b00;
        end else if (trap_fire) begin
            unique case (tgt_priv)
                PRIV_U: begin
                    pie_q[0] <= ie_q[0];
                    ie_q[0]  <= 1'b0;
                end
                PRIV_S: begin
                    pie_q[1] <= ie_q[1];
                    ie_q[1]  <= 1'b0;
                    spp_q    <= (cur_priv != PRIV_U);
                end
                default: begin
                    pie_q[2] <= ie_q[2];
                    ie_q[2]  <= 1'b0;
                    mpp_q    <= cur_priv;
                end
            endcase
        end else if (ld_en) begin
            ie_q <= ld_ie;
        end
    end

    a_r8_mie_pushed: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fire && tgt_priv == PRIV_M) |=>
            (!ie_q[2] && pie_q[2] == $past(ie_q[2]) && mpp_q == $past(cur_priv)));

    a_r7_sie_pushed: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fire && tgt_priv == PRIV_S) |=>
            (!ie_q[1] && pie_q[1] == $past(ie_q[1])));

    a_r6_uie_pushed: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fire && tgt_priv == PRIV_U) |=>
            (!ie_q[0] && pie_q[0] == $past(ie_q[0])));

endmodule

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
    import trap_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 5,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
    localparam int             NCODE     = 1 << CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic [CODE_W-1:0]   trap_code,
    input  logic                trap_is_irq,
    input  logic [XLEN-1:0]     trap_pc,
    input  logic [NCODE-1:0]    medeleg_mask,
    input  logic [NCODE-1:0]    sedeleg_mask,
    input  logic [XLEN-1:0]     utvec,
    input  logic [XLEN-1:0]     stvec,
    input  logic [XLEN-1:0]     mtvec,
    input  logic                mode_ld_en,
    input  logic [1:0]          mode_ld_priv,
    input  logic [2:0]          mode_ld_ie,
    output logic [1:0]          priv_mode,
    output logic                trap_taken,
    output logic                redirect_valid,
    output logic [XLEN-1:0]     redirect_pc,
    output logic [XLEN-1:0]     ucause,
    output logic [XLEN-1:0]     scause,
    output logic [XLEN-1:0]     mcause,
    output logic [XLEN-1:0]     uepc,
    output logic [XLEN-1:0]     sepc,
    output logic [XLEN-1:0]     mepc,
    output logic [2:0]          status_ie,
    output logic [2:0]          status_pie,
    output logic                status_spp,
    output logic [1:0]          status_mpp
);

    ctl_state_e state_q, state_d;
    priv_e      priv_q;
    priv_e      tgt_priv;
    logic [XLEN-1:0] tvec_sel;
    logic [NUM_LEVELS-1:0][XLEN-1:0] cause_q, epc_q;

    // Handler level selection
    trap_deleg #(.CODE_W(CODE_W)) u_deleg (
        .cur_priv (priv_q),
        .code     (trap_code),
        .medeleg  (medeleg_mask),
        .sedeleg  (sedeleg_mask),
        .tgt_priv (tgt_priv)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;   // boot_done
            ST_RUN:  state_d = ST_RUN;   // trap_commit or idle
            default: state_d = ST_BOOT;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (tgt_priv)
            PRIV_U:  tvec_sel = utvec;
            PRIV_S:  tvec_sel = stvec;
            default: tvec_sel = mtvec;
        endcase
    end

    always_comb begin
        trap_taken     = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        unique case (state_q)
            ST_BOOT: begin
                redirect_valid = 1'b1;
                redirect_pc    = RESET_VEC;
            end
            ST_RUN: begin
                if (trap_req) begin
                    trap_taken     = 1'b1;
                    redirect_valid = 1'b1;
                    redirect_pc    = {tvec_sel[XLEN-1:2], 2'b00};
                end
            end
            default: ;
        endcase
    end

    // Privilege register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_M;
        end else if (trap_taken) begin
            priv_q <= tgt_priv;
        end else if (mode_ld_en && mode_ld_priv != 2'b10) begin
            priv_q <= priv_e'(mode_ld_priv);
        end
    end

    trap_csr_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trap_taken),
        .wr_row  (level_row(tgt_priv)),
        .code    (trap_code),
        .is_irq  (trap_is_irq),
        .pc      (trap_pc),
        .cause_q (cause_q),
        .epc_q   (epc_q)
    );

    trap_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_fire (trap_taken),
        .tgt_priv  (tgt_priv),
        .cur_priv  (priv_q),
        .ld_en     (mode_ld_en),
        .ld_ie     (mode_ld_ie),
        .ie_q      (status_ie),
        .pie_q     (status_pie),
        .spp_q     (status_spp),
        .mpp_q     (status_mpp)
    );

    assign priv_mode = priv_q;
    assign ucause    = cause_q[0];
    assign scause    = cause_q[1];
    assign mcause    = cause_q[2];
    assign uepc      = epc_q[0];
    assign sepc      = epc_q[1];
    assign mepc      = epc_q[2];

    a_r9_taken_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (redirect_valid && redirect_pc[1:0] == 2'b00));

    a_r9_priv_follows: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (priv_mode == $past(tgt_priv)));

    a_r2_machine_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_q == PRIV_M) |-> (tgt_priv == PRIV_M));

    a_r10_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
        priv_mode != 2'b10);

    a_r1_boot_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> !trap_taken);

endmodule

// File: tb/tb_trap_entry_ctl.sv
module tb_trap_entry_ctl;

    localparam int XLEN = 16;
    localparam int CODE_W = 4;
    localparam logic [15:0] RVEC = 16'h0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 1'b0;
    logic [3:0] trap_code = '0;
    logic trap_is_irq = 1'b0;
    logic [15:0] trap_pc = '0;
    logic [15:0] medeleg_mask = '0, sedeleg_mask = '0;
    logic [15:0] utvec = 16'h1103, stvec = 16'h2202, mtvec = 16'h3301;
    logic mode_ld_en = 1'b0;
    logic [1:0] mode_ld_priv = 2'b11;
    logic [2:0] mode_ld_ie = '0;
    logic [1:0] priv_mode;
    logic trap_taken, redirect_valid;
    logic [15:0] redirect_pc, ucause, scause, mcause, uepc, sepc, mepc;
    logic [2:0] status_ie, status_pie;
    logic status_spp;
    logic [1:0] status_mpp;

    trap_entry_ctl #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RVEC)) dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_code(trap_code),
        .trap_is_irq(trap_is_irq), .trap_pc(trap_pc),
        .medeleg_mask(medeleg_mask), .sedeleg_mask(sedeleg_mask),
        .utvec(utvec), .stvec(stvec), .mtvec(mtvec),
        .mode_ld_en(mode_ld_en), .mode_ld_priv(mode_ld_priv), .mode_ld_ie(mode_ld_ie),
        .priv_mode(priv_mode), .trap_taken(trap_taken),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .ucause(ucause), .scause(scause), .mcause(mcause),
        .uepc(uepc), .sepc(sepc), .mepc(mepc),
        .status_ie(status_ie), .status_pie(status_pie),
        .status_spp(status_spp), .status_mpp(status_mpp)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [1:0]  m_priv;
    logic [2:0]  m_ie, m_pie;
    logic        m_spp;
    logic [1:0]  m_mpp;
    logic [15:0] m_cause [3];
    logic [15:0] m_epc [3];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_priv = 2'b11; m_ie = '0; m_pie = '0; m_spp = 1'b0; m_mpp = 2'b00;
        for (int i = 0; i < 3; i++) begin
            m_cause[i] = '0; m_epc[i] = '0;
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "priv", 32'(priv_mode), 32'(m_priv));
        chk(req, "ie", 32'(status_ie), 32'(m_ie));
        chk(req, "pie", 32'(status_pie), 32'(m_pie));
        chk(req, "spp", 32'(status_spp), 32'(m_spp));
        chk(req, "mpp", 32'(status_mpp), 32'(m_mpp));
        chk(req, "ucause", 32'(ucause), 32'(m_cause[0]));
        chk(req, "scause", 32'(scause), 32'(m_cause[1]));
        chk(req, "mcause", 32'(mcause), 32'(m_cause[2]));
        chk(req, "uepc", 32'(uepc), 32'(m_epc[0]));
        chk(req, "sepc", 32'(sepc), 32'(m_epc[1]));
        chk(req, "mepc", 32'(mepc), 32'(m_epc[2]));
    endtask

    // Computes the handler level (R2, R3) and applies the trap to the model.
    task automatic model_trap(input logic [3:0] code, input logic irq,
                              input logic [15:0] pc, input logic mdel,
                              input logic sdel, output logic [1:0] tgt);
        int row;
        tgt = 2'b11;
        if (m_priv != 2'b11 && mdel) tgt = 2'b01;
        if (m_priv == 2'b00 && sdel) tgt = 2'b00;
        row = (tgt == 2'b00) ? 0 : (tgt == 2'b01) ? 1 : 2;
        m_cause[row] = {irq, 11'd0, code};  // R4
        m_epc[row] = pc;                    // R5
        m_pie[row] = m_ie[row];             // R6 R7 R8
        m_ie[row] = 1'b0;
        if (tgt == 2'b01) m_spp = (m_priv != 2'b00);
        if (tgt == 2'b11) m_mpp = m_priv;
        m_priv = tgt;
    endtask

    function automatic logic [15:0] vec_of(input logic [1:0] t);
        return (t == 2'b00) ? 16'h1100 : (t == 2'b01) ? 16'h2200 : 16'h3300;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] tgt;
        int n;
        model_reset();
        trap_req = 1'b1;  // must be ignored through reset and boot (R1)
        trap_code = 4'd3;
        repeat (3) @(negedge clk);
        check_state("R1");
        chk("R1", "taken in reset", 32'(trap_taken), 0);
        rst_n = 1'b1;
        #2;
        chk("R1", "boot redirect_valid", 32'(redirect_valid), 1);
        chk("R1", "boot redirect_pc", 32'(redirect_pc), 32'(RVEC));
        chk("R1", "boot taken", 32'(trap_taken), 0);
        @(negedge clk);
        trap_req = 1'b0;
        @(negedge clk);
        check_state("R1");

        // Exhaustive sweep: origin level x code x irq x delegation bits
        n = 0;
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int q = 0; q < 2; q++) begin
                    for (int d = 0; d < 4; d++) begin
                        logic [1:0] pv;
                        logic [15:0] pc;
                        pv = (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : 2'b11;
                        mode_ld_en = 1'b1;
                        mode_ld_priv = pv;
                        mode_ld_ie = 3'(n);
                        @(negedge clk);
                        mode_ld_en = 1'b0;
                        m_priv = pv;
                        m_ie = 3'(n);
                        pc = 16'h4000 + 16'(n * 6);
                        trap_req = 1'b1;
                        trap_code = 4'(c);
                        trap_is_irq = q[0];
                        trap_pc = pc;
                        medeleg_mask = d[0] ? (16'h1 << c) : ~(16'h1 << c);
                        sedeleg_mask = d[1] ? (16'h1 << c) : ~(16'h1 << c);
                        model_trap(4'(c), q[0], pc, d[0], d[1], tgt);
                        #2;
                        chk("R9", "trap_taken", 32'(trap_taken), 1);
                        chk("R9", "redirect_valid", 32'(redirect_valid), 1);
                        chk(tgt == 2'b11 ? "R2" : (tgt == 2'b01 ? "R2" : "R3"),
                            "redirect_pc", 32'(redirect_pc), 32'(vec_of(tgt)));
                        @(negedge clk);
                        trap_req = 1'b0;
                        check_state(tgt == 2'b00 ? "R6" : (tgt == 2'b01 ? "R7" : "R8"));
                        n++;
                    end
                end
            end
        end

        // R10: reserved privilege code keeps the level, enables still load
        mode_ld_en = 1'b1; mode_ld_priv = 2'b01; mode_ld_ie = 3'b010;
        @(negedge clk);
        m_priv = 2'b01; m_ie = 3'b010;
        mode_ld_priv = 2'b10; mode_ld_ie = 3'b111;
        @(negedge clk);
        mode_ld_en = 1'b0;
        m_ie = 3'b111;
        check_state("R10");

        // R10: load colliding with a trap is dropped
        mode_ld_en = 1'b1; mode_ld_priv = 2'b00; mode_ld_ie = 3'b000;
        trap_req = 1'b1; trap_code = 4'd5; trap_is_irq = 1'b1; trap_pc = 16'hBEE4;
        medeleg_mask = '0; sedeleg_mask = '0;
        model_trap(4'd5, 1'b1, 16'hBEE4, 1'b0, 1'b0, tgt);
        @(negedge clk);
        mode_ld_en = 1'b0; trap_req = 1'b0;
        check_state("R10");

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        model_reset();
        check_state("R1");
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule